// File: doc/BRIEF.md
# Carry-Extended Stack ALU

This block is the arithmetic and logic stage of a small stack processor. It takes the top data-stack word and the word below it. Each word is 21 bits wide: 20 bits of data, with bit 20 used as the carry bit. A 3-bit select chooses the operation. The block returns a replacement top word, together with a flag that tells the surrounding stack logic whether the second word must be popped.

Operands and select are sampled while `valid_in` is high. The result appears one clock later on registered outputs with `valid_out`. While `valid_in` is low, the registered top word keeps its value and no pop is requested. The block holds no stack storage and does not access memory.

Top module: `stk_alu`

## Requirements
- R1: On a clock edge with `rst_n` low, `t_out` becomes 0 and `valid_out` and `pop_s` become 0.
- R2: `valid_out` equals `valid_in` delayed by one clock. When `valid_in` is low, `t_out` holds its value and `pop_s` is 0.
- R3: Select code 0 gives the bitwise AND of all 21 bits of T and S. Code 1 gives the bitwise XOR of all 21 bits. Both request a pop.
- R4: Select code 2 inverts all 21 bits of T, carry bit included, and requests no pop.
- R5: Select code 3 adds bits 19..0 of T and S into a 21-bit result whose bit 20 is the carry out. Input bits 20 are ignored. It requests a pop.
- R6: Select code 4 returns T bits 19..0 shifted into bits 20..1, with bit 0 cleared, and requests no pop.
- R7: Select code 5 keeps T bits 20 and 19 and places T bits 19..1 into bits 18..0. It requests no pop.
- R8: Select code 6 with T bit 0 set returns the same sum as code 3 and requests no pop.
- R9: Select code 6 with T bit 0 clear returns T unchanged and requests no pop.
- R10: Select code 7 returns T unchanged and requests no pop.
- R11: `pop_s` is high only together with `valid_out`, and only for codes 0, 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_in | input | 1 | Operands and select are valid this cycle |
| op_sel | input | 3 | Operation select code |
| t_in | input | 21 | Top stack word, carry in bit 20 |
| s_in | input | 21 | Second stack word |
| t_out | output | 21 | Registered new top word |
| pop_s | output | 1 | Second word must be removed from the stack |
| valid_out | output | 1 | Outputs carry a new result |

## Verification
On every cycle, the embedded assertions check the pop flag rules, the one-cycle valid delay, the hold of the top word when idle, inversion, the sign-bit preservation of the right shift, and the no-add case of the conditional add. Exact sums, carry generation into bit 20 and the shift-left bit movement are shown by the bench. It compares every result against its own model, using random operands and directed corner values such as all-ones, a set carry and an alternating pattern.

// File: rtl/stk_alu_pkg.sv
// Package: operation codes and word geometry shared by the stack ALU.
// Assumes the select field is exactly 3 bits wide.
package stk_alu_pkg;
    localparam int unsigned DATA_W = 20;
    localparam int unsigned WORD_W = DATA_W + 1;

    typedef enum logic [2:0] {
        OP_AND   = 3'd0,
        OP_XOR   = 3'd1,
        OP_COM   = 3'd2,
        OP_ADD   = 3'd3,
        OP_SHL   = 3'd4,
        OP_SHR   = 3'd5,
        OP_ADDNZ = 3'd6,
        OP_PASS  = 3'd7
    } alu_op_e;
endpackage

// File: rtl/stk_alu_arith.sv
// Adder for the add and conditional-add paths.
// Sums the data bits of both words and returns the carry out in the top result bit.
// Assumes the caller strips the carry bit from the operands.
module stk_alu_arith #(
    parameter int unsigned DW = 20
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW:0]   sum_o
);
    // zero-extended sum so the carry lands in bit DW
    always_comb begin
        sum_o = {1'b0, a_i} + {1'b0, b_i};
    end
endmodule

// File: rtl/stk_alu_bitwise.sv
// Logic and shift paths of the stack ALU.
// Operates on full words of DW+1 bits, where bit DW is the carry.
// Assumes DW >= 2 so that the two preserved right-shift bits exist.
module stk_alu_bitwise #(
    parameter int unsigned DW = 20
) (
    input  logic [DW:0] t_i,
    input  logic [DW:0] s_i,
    output logic [DW:0] and_o,
    output logic [DW:0] xor_o,
    output logic [DW:0] com_o,
    output logic [DW:0] shl_o,
    output logic [DW:0] shr_o
);
    // bitwise combine and invert across the whole word
    always_comb begin
        and_o = t_i & s_i;
        xor_o = t_i ^ s_i;
        com_o = ~t_i;
    end

    // left shift passes data bit DW-1 into the carry; right shift keeps the two top bits
    always_comb begin
        shl_o = {t_i[DW-1:0], 1'b0};
        shr_o = {t_i[DW], t_i[DW-1], t_i[DW-1:1]};
    end
endmodule

// File: rtl/stk_alu.sv
// Top of the stack ALU: selects one operation result and registers it.
// The pop request is registered with the result.
// Assumes operands are stable while valid_in is high; one cycle of latency.
module stk_alu
    import stk_alu_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_in,
    input  logic [2:0]    op_sel,
    input  logic [DW:0]   t_in,
    input  logic [DW:0]   s_in,
    output logic [DW:0]   t_out,
    output logic          pop_s,
    output logic          valid_out
);
    localparam int unsigned WW = DW + 1;

    alu_op_e      op;
    logic [WW-1:0] and_w, xor_w, com_w, shl_w, shr_w, sum_w;
    logic [WW-1:0] next_t;
    logic          next_pop;

    assign op = alu_op_e'(op_sel);

    stk_alu_bitwise #(.DW(DW)) bitwise_i (
        .t_i(t_in), .s_i(s_in),
        .and_o(and_w), .xor_o(xor_w), .com_o(com_w),
        .shl_o(shl_w), .shr_o(shr_w)
    );

    stk_alu_arith #(.DW(DW)) arith_i (
        .a_i(t_in[DW-1:0]), .b_i(s_in[DW-1:0]), .sum_o(sum_w)
    );

    // pick the result and the pop request for the selected operation
    always_comb begin
        next_pop = 1'b0;
        unique case (op)
            OP_AND:   begin next_t = and_w; next_pop = 1'b1; end
            OP_XOR:   begin next_t = xor_w; next_pop = 1'b1; end
            OP_COM:   next_t = com_w;
            OP_ADD:   begin next_t = sum_w; next_pop = 1'b1; end
            OP_SHL:   next_t = shl_w;
            OP_SHR:   next_t = shr_w;
            OP_ADDNZ: next_t = t_in[0] ? sum_w : t_in;
            default:  next_t = t_in;
        endcase
    end

    // result register: loads on valid, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_out     <= '0;
            pop_s     <= 1'b0;
            valid_out <= 1'b0;
        end else begin
            valid_out <= valid_in;
            pop_s     <= valid_in & next_pop;
            if (valid_in) t_out <= next_t;
        end
    end

    a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> ($stable(t_out) && !pop_s && !valid_out));
    a_r4_com_inverts: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op_sel == 3'd2) |=> (t_out == ~$past(t_in)));
    a_r7_shr_keeps_top: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op_sel == 3'd5) |=> (t_out[DW:DW-1] == $past(t_in[DW:DW-1])));
    a_r9_addnz_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op_sel == 3'd6 && !t_in[0]) |=> (t_out == $past(t_in)));
    a_r11_pop_ops: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> (pop_s == ($past(op_sel) inside {3'd0, 3'd1, 3'd3})));
    a_r11_pop_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pop_s |-> valid_out);
endmodule

// File: tb/stk_alu_tb.sv
// Self-checking bench: directed corners plus seeded random operands.
module stk_alu_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_in = 1'b0;
    logic [2:0]    op_sel = '0;
    logic [DW:0]   t_in = '0, s_in = '0;
    logic [DW:0]   t_out;
    logic          pop_s, valid_out;
    int            n_tests = 0, n_fail = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stk_alu #(.DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op_sel(op_sel),
        .t_in(t_in), .s_in(s_in), .t_out(t_out), .pop_s(pop_s), .valid_out(valid_out)
    );

    function automatic logic [DW:0] model_t(input logic [2:0] op, input logic [DW:0] t, input logic [DW:0] s);
        logic [DW:0] sum;
        sum = {1'b0, t[DW-1:0]} + {1'b0, s[DW-1:0]};
        case (op)
            3'd0: return t & s;
            3'd1: return t ^ s;
            3'd2: return ~t;
            3'd3: return sum;
            3'd4: return t << 1;
            3'd5: return {t[DW], t[DW-1], t[DW-1:1]};
            3'd6: return t[0] ? sum : t;
            default: return t;
        endcase
    endfunction

    function automatic logic model_pop(input logic [2:0] op);
        return (op == 3'd0) || (op == 3'd1) || (op == 3'd3);
    endfunction

    function automatic string req_of(input logic [2:0] op, input logic [DW:0] t);
        case (op)
            3'd0, 3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return t[0] ? "R8" : "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive one operation at a falling edge, check after the capturing rising edge
    task automatic run_op(input logic [2:0] op, input logic [DW:0] t, input logic [DW:0] s);
        string r;
        r = req_of(op, t);
        valid_in = 1'b1; op_sel = op; t_in = t; s_in = s;
        @(negedge clk);
        check(r, "t_out", 32'(t_out), 32'(model_t(op, t, s)));
        check(r, "pop_s", 32'(pop_s), 32'(model_pop(op)));
        check("R11", "pop_s", 32'(pop_s), 32'(model_pop(op)));
        check("R2", "valid_out", 32'(valid_out), 32'd1);
    endtask

    initial begin
        logic [DW:0] held;
        void'($urandom(32'd1234));
        @(negedge clk); @(negedge clk);
        check("R1", "t_out", 32'(t_out), 32'd0);
        check("R1", "pop_s", 32'(pop_s), 32'd0);
        check("R1", "valid_out", 32'(valid_out), 32'd0);
        rst_n = 1'b1;

        run_op(3'd0, 21'h1FFFFF, 21'h155555);
        run_op(3'd1, 21'h1FFFFF, 21'h0AAAAA);
        run_op(3'd2, 21'h100000, 21'h0);
        run_op(3'd2, 21'h0AAAAA, 21'h0);
        run_op(3'd3, 21'h0FFFFF, 21'h000001);
        run_op(3'd3, 21'h1FFFFF, 21'h1FFFFF);
        run_op(3'd4, 21'h080001, 21'h0);
        run_op(3'd4, 21'h100000, 21'h0);
        run_op(3'd5, 21'h180003, 21'h0);
        run_op(3'd5, 21'h100002, 21'h0);
        run_op(3'd6, 21'h0FFFFF, 21'h000001);
        run_op(3'd6, 21'h0FFFFE, 21'h000001);
        run_op(3'd7, 21'h12345, 21'h1FFFFF);

        // R2: idle cycle holds the result and raises nothing
        held = t_out;
        valid_in = 1'b0; op_sel = 3'd2; t_in = 21'h0; s_in = 21'h1FFFFF;
        @(negedge clk);
        check("R2", "t_out hold", 32'(t_out), 32'(held));
        check("R2", "valid_out", 32'(valid_out), 32'd0);
        check("R2", "pop_s idle", 32'(pop_s), 32'd0);

        for (int i = 0; i < 300; i++) begin
            run_op(3'($urandom_range(0, 7)), 21'($urandom), 21'($urandom));
        end

        // R1: synchronous reset clears a loaded result
        rst_n = 1'b0; valid_in = 1'b0;
        @(negedge clk);
        check("R1", "t_out after reset", 32'(t_out), 32'd0);
        check("R1", "valid_out after reset", 32'(valid_out), 32'd0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule